// File: doc/BRIEF.md
# Configurable Register Logic Cell

This block is one storage site of a programmable logic fabric: a single flip-flop with a small set of static configuration bits around it. The configuration picks which of four clock nets drives the cell, whether the cell acts on the rising or the falling edge of that net, and whether the flip-flop loads the fast input from the adjacent cell or the general routed data input. Fabric routing and the loading of the configuration bits are handled outside the cell.

Loading is gated by two separate control lines, and both must be high for the flip-flop to take new data. An asynchronous clear and an asynchronous preset force the stored bit directly, and clear wins when both are active. A chip-level active-low reset clears the cell at once. Its release is brought into line with the cell's own effective clock through a short synchronizer, so the cell comes out of reset cleanly on whichever clock and edge it has been configured for.

Top module: `rlc_reg_cell`

## Requirements
- R1: `cfg_clk_sel_i` selects the clock net: 0 = dedicated hardwired clock, 1 = routed clock A, 2 = routed clock B, 3 = internal-logic clock. Edges on the three unselected nets never change `y_o`.
- R2: With `cfg_clk_inv_i` = 0 the cell acts on the rising edge of the selected net. With `cfg_clk_inv_i` = 1 it acts on the falling edge, and a rising edge leaves `y_o` unchanged.
- R3: `cfg_din_sel_i` = 0 loads `d_nbr_i` (adjacent-cell input). `cfg_din_sel_i` = 1 loads `d_rte_i` (routed input).
- R4: On an active clock edge the cell loads only when both `en_a_i` and `en_b_i` are 1. If either is 0, `y_o` holds its value.
- R5: `clr_i` (active high) forces `y_o` to 0 at once, without a clock edge. It overrides `pre_i` and any clock edge for as long as it is asserted.
- R6: `pre_i` (active high) forces `y_o` to 1 at once when `clr_i` is 0.
- R7: `rst_n` low forces `y_o` to 0 at once. After `rst_n` rises, `y_o` stays 0 for the first `RST_STAGES` (default 2) active edges of the effective clock. The first enabled active edge after that loads data. `y_o` always equals the stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Chip-level asynchronous reset, active low |
| clk_hard_i | input | 1 | Dedicated hardwired clock net |
| clk_rta_i | input | 1 | Routed clock net A |
| clk_rtb_i | input | 1 | Routed clock net B |
| clk_int_i | input | 1 | Clock produced by internal logic |
| cfg_clk_sel_i | input | 2 | Static clock-source selection |
| cfg_clk_inv_i | input | 1 | Static edge selection, 1 = falling edge |
| cfg_din_sel_i | input | 1 | Static data-source selection, 1 = routed input |
| d_nbr_i | input | 1 | Fast data input from the adjacent cell |
| d_rte_i | input | 1 | General routed data input |
| en_a_i | input | 1 | First enable control line |
| en_b_i | input | 1 | Second enable control line |
| clr_i | input | 1 | Asynchronous clear, active high |
| pre_i | input | 1 | Asynchronous preset, active high |
| y_o | output | 1 | Stored bit |

## Verification
A vector table walks every clock source under both edge settings. Each vector samples `y_o` between the rising and the falling half of the source pulse, and this separates the two polarities: a rising-edge cell has already updated at that point and a falling-edge cell has not. The adjacent and routed inputs are always given opposite values when a load is expected, so loading from the wrong input shows up. Every vector ends with an enabled pulse on a net that is not selected, which exposes a wrong clock multiplexer. Vectors with only one enable line high, or neither, show that a single control line cannot load the cell. Directed tests then apply clear and preset alone and together, a clock edge under clear, and the reset release sequence, where the count of suppressed edges tells whether the synchronizer is present and has the right depth.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  // Clock net encoding used by the static clock-select bits.
  typedef enum logic [1:0] {
    CK_HARD = 2'd0,
    CK_RTA  = 2'd1,
    CK_RTB  = 2'd2,
    CK_INT  = 2'd3
  } ck_src_e;

  localparam int unsigned NUM_CK   = 4;
  localparam int unsigned CK_SEL_W = $clog2(NUM_CK);

  // Data source encoding.
  typedef enum logic {
    DIN_NBR = 1'b0,
    DIN_RTE = 1'b1
  } din_src_e;

endpackage

// File: rtl/rlc_clk_sel.sv
module rlc_clk_sel
  import rlc_pkg::*;
#(
  parameter int unsigned N_CK = NUM_CK
) (
  input  logic [N_CK-1:0]     ck_i,
  input  logic [CK_SEL_W-1:0] sel_i,
  input  logic                inv_i,
  output logic                ck_eff_o
);

  logic ck_pick;

  // Behavioural model of the per-cell clock multiplexer.
  always_comb begin
    ck_pick = 1'b0;
    for (int k = 0; k < int'(N_CK); k++) begin
      if (sel_i == k[CK_SEL_W-1:0]) ck_pick = ck_i[k];
    end
  end

  // Edge selection: an inverted net turns a falling edge into an active rising one.
  assign ck_eff_o = ck_pick ^ inv_i;

endmodule

// File: rtl/rlc_din_sel.sv
module rlc_din_sel
  import rlc_pkg::*;
(
  input  logic     d_nbr_i,
  input  logic     d_rte_i,
  input  din_src_e sel_i,
  output logic     d_o
);

  always_comb begin
    unique case (sel_i)
      DIN_NBR: d_o = d_nbr_i;
      DIN_RTE: d_o = d_rte_i;
      default: d_o = d_nbr_i;
    endcase
  end

endmodule

// File: rtl/rlc_rst_sync.sv
module rlc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic ck_i,
  input  logic rst_n,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge ck_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      logic [STAGES-1:0] chain_d;
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
      always_ff @(posedge ck_i or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
    end
  endgenerate

  assign rst_sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rlc_store.sv
module rlc_store (
  input  logic ck_i,
  input  logic rst_n,
  input  logic rst_sync_n_i,
  input  logic clr_i,
  input  logic pre_i,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic d_i,
  output logic q_o
);

  logic clr_any;
  logic load_en;
  logic q_next;
  logic q_r;

  assign clr_any = clr_i | ~rst_sync_n_i;

  // Enable is formed from both control lines.
  always_comb begin
    load_en = en_a_i & en_b_i;
    q_next  = load_en ? d_i : q_r;
  end

  // Clear has priority over preset; both override the clock.
  always_ff @(posedge ck_i or posedge clr_any or posedge pre_i) begin
    if (clr_any)    q_r <= 1'b0;
    else if (pre_i) q_r <= 1'b1;
    else            q_r <= q_next;
  end

  assign q_o = q_r;

  // Marks that an asynchronous force acted since the last active edge.
  logic async_seen;
  always_ff @(posedge ck_i or posedge clr_any or posedge pre_i) begin
    if (clr_any || pre_i) async_seen <= 1'b1;
    else                  async_seen <= 1'b0;
  end

  a_r4_load: assert property (@(posedge ck_i) disable iff (!rst_n)
    (!async_seen && $past(en_a_i && en_b_i)) |-> (q_o == $past(d_i)))
    else $error("R4 enabled edge did not load");

  a_r4_hold: assert property (@(posedge ck_i) disable iff (!rst_n)
    (!async_seen && !$past(en_a_i && en_b_i)) |-> (q_o == $past(q_o)))
    else $error("R4 disabled edge changed the cell");

  a_r5_clr_wins: assert property (@(posedge ck_i) disable iff (!rst_n)
    clr_i |-> (q_o == 1'b0))
    else $error("R5 clear not holding output low");

  a_r6_pre_sets: assert property (@(posedge ck_i) disable iff (!rst_n)
    (pre_i && !clr_i && rst_sync_n_i) |-> (q_o == 1'b1))
    else $error("R6 preset not holding output high");

  a_r7_sync_clear: assert property (@(posedge ck_i) disable iff (!rst_n)
    !rst_sync_n_i |-> (q_o == 1'b0))
    else $error("R7 output not cleared before reset release");

endmodule

// File: rtl/rlc_reg_cell.sv
module rlc_reg_cell
  import rlc_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       rst_n,
  input  logic       clk_hard_i,
  input  logic       clk_rta_i,
  input  logic       clk_rtb_i,
  input  logic       clk_int_i,
  input  logic [1:0] cfg_clk_sel_i,
  input  logic       cfg_clk_inv_i,
  input  logic       cfg_din_sel_i,
  input  logic       d_nbr_i,
  input  logic       d_rte_i,
  input  logic       en_a_i,
  input  logic       en_b_i,
  input  logic       clr_i,
  input  logic       pre_i,
  output logic       y_o
);

  logic [NUM_CK-1:0] ck_nets;
  logic              ck_eff;
  logic              d_pick;
  logic              rst_sync_n;

  // Net order follows the clock-select encoding.
  always_comb begin
    ck_nets          = '0;
    ck_nets[CK_HARD] = clk_hard_i;
    ck_nets[CK_RTA]  = clk_rta_i;
    ck_nets[CK_RTB]  = clk_rtb_i;
    ck_nets[CK_INT]  = clk_int_i;
  end

  rlc_clk_sel #(.N_CK(NUM_CK)) i_clk_sel (
    .ck_i     (ck_nets),
    .sel_i    (cfg_clk_sel_i),
    .inv_i    (cfg_clk_inv_i),
    .ck_eff_o (ck_eff)
  );

  rlc_din_sel i_din_sel (
    .d_nbr_i (d_nbr_i),
    .d_rte_i (d_rte_i),
    .sel_i   (din_src_e'(cfg_din_sel_i)),
    .d_o     (d_pick)
  );

  rlc_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .ck_i         (ck_eff),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_sync_n)
  );

  rlc_store i_store (
    .ck_i         (ck_eff),
    .rst_n        (rst_n),
    .rst_sync_n_i (rst_sync_n),
    .clr_i        (clr_i),
    .pre_i        (pre_i),
    .en_a_i       (en_a_i),
    .en_b_i       (en_b_i),
    .d_i          (d_pick),
    .q_o          (y_o)
  );

endmodule

// File: tb/test_rlc_reg_cell.sv
`timescale 1ns/1ps
module test_rlc_reg_cell;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] src;
  logic [1:0] csel;
  logic       cinv, dsel, dnb, drt, ena, enb, clr, pre;
  logic       y;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  rlc_reg_cell i_rlc_reg_cell (
    .rst_n(rst_n), .clk_hard_i(src[0]), .clk_rta_i(src[1]), .clk_rtb_i(src[2]),
    .clk_int_i(src[3]), .cfg_clk_sel_i(csel), .cfg_clk_inv_i(cinv),
    .cfg_din_sel_i(dsel), .d_nbr_i(dnb), .d_rte_i(drt), .en_a_i(ena),
    .en_b_i(enb), .clr_i(clr), .pre_i(pre), .y_o(y)
  );

  // {sel[1:0], inv, dsel, en_a, en_b, d_nbr, d_rte, expected y}
  localparam logic [8:0] VEC [16] = '{
    9'b00_0_0_11_10_1, 9'b00_1_1_11_10_0, 9'b01_0_0_11_10_1, 9'b01_1_1_11_10_0,
    9'b10_0_1_11_01_1, 9'b10_1_0_11_01_0, 9'b11_0_0_11_10_1, 9'b11_1_1_11_10_0,
    9'b00_0_0_10_10_0, 9'b01_1_1_01_01_0, 9'b10_0_0_00_10_0, 9'b11_1_1_11_01_1,
    9'b00_1_0_01_00_1, 9'b01_0_1_10_00_1, 9'b10_1_1_11_10_0, 9'b11_0_0_11_10_1
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: y=%b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(input int idx);
    src[idx] = 1'b1; #4;
    src[idx] = 1'b0; #4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, y=%b expected completion", y);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    src = '0; csel = 2'd0; cinv = 1'b0; dsel = 1'b0; dnb = 1'b0; drt = 1'b0;
    ena = 1'b0; enb = 1'b0; clr = 1'b0; pre = 1'b0; rst_n = 1'b1;
    #10 rst_n = 1'b0;
    #6 check("R7 reset forces zero", y, 1'b0);
    pulse(0); pulse(0);
    #4 rst_n = 1'b1;
    // R7: release, then edges with enable low keep zero
    dnb = 1'b1; pulse(0); pulse(0); pulse(0);
    check("R7 zero until enabled edge", y, 1'b0);

    // Vector walk: R1 R2 R3 R4
    for (int v = 0; v < 16; v++) begin
      logic [8:0] e;
      logic       prior;
      int         sel;
      int         other;
      e     = VEC[v];
      prior = y;
      sel   = int'(e[8:7]);
      other = (sel + 1) % 4;
      ena = 1'b0; enb = 1'b0; #1;
      csel = e[8:7]; cinv = e[6]; dsel = e[5]; #2;
      dnb = e[2]; drt = e[1]; #1;
      ena = e[4]; enb = e[3]; #2;
      src[sel] = 1'b1; #4;
      check(e[6] ? "R2 falling-edge cell ignores rising edge" : "R2 rising-edge cell updates",
            y, e[6] ? prior : e[0]);
      src[sel] = 1'b0; #4;
      check((e[4] & e[3]) ? "R3 selected data loaded" : "R4 single control line holds",
            y, e[0]);
      // R1: enabled pulse on an unselected net must not load
      if (e[5]) drt = ~e[0]; else dnb = ~e[0];
      ena = 1'b1; enb = 1'b1; #2;
      pulse(other);
      check("R1 unselected clock net ignored", y, e[0]);
      ena = 1'b0; enb = 1'b0; #2;
    end

    // Directed: asynchronous controls, clock idle (y=1 here)
    clr = 1'b1; #2 check("R5 clear without clock", y, 1'b0);
    clr = 1'b0; #2;
    pre = 1'b1; #2 check("R6 preset without clock", y, 1'b1);
    clr = 1'b1; #2 check("R5 clear beats preset", y, 1'b0);
    pre = 1'b0; #2 clr = 1'b0; #2;
    pre = 1'b1; #2 pre = 1'b0; #2;
    check("R6 preset pulse sets", y, 1'b1);
    clr = 1'b1; dnb = 1'b1; ena = 1'b1; enb = 1'b1; #2;
    pulse(3);
    check("R5 clear overrides enabled edge", y, 1'b0);
    ena = 1'b0; enb = 1'b0; #1 clr = 1'b0; #2;

    // Directed: reset mid-run and synchronized release
    pre = 1'b1; #2 pre = 1'b0; #2;
    rst_n = 1'b0; #2 check("R7 reset clears at once", y, 1'b0);
    ena = 1'b1; enb = 1'b1; dnb = 1'b1; #2;
    pulse(3);
    check("R7 held low during reset", y, 1'b0);
    rst_n = 1'b1; #2;
    pulse(3); pulse(3);
    check("R7 edges inside synchronizer suppressed", y, 1'b0);
    pulse(3);
    check("R7 first edge after synchronizer loads", y, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule